// File: doc/BRIEF.md
# Byte-Wide MIDI Host Port with Serial Link

This block gives a host a two-register, byte-wide window onto a serial MIDI link. Offset 0 carries data in both directions. Offset 1 takes command bytes on a write and returns a status byte on a read. Behind the window sit a small transmit buffer that feeds a UART serializer and a small receive buffer that collects bytes from a UART deserializer. The receive buffer also holds the acknowledge bytes that the port produces in answer to commands.

Only two command codes have any effect. 0xFF resets the port. 0x3F switches it into pass-through (UART) mode. Both answer with the acknowledge byte 0xFE. Every other command code is ignored. Until UART mode is entered, data writes and incoming serial frames are discarded. The two status flags are active-low. A level output tells the host that the receive buffer holds a byte. The serial bit period is a fixed number of clock cycles set by a parameter.

Top module: `midi_uart_port`

## Requirements
- R1: Status bit 7 reads 0 exactly when the receive buffer holds at least one byte. `rx_avail` is 1 under the same condition.
- R2: Status bit 6 reads 0 exactly when the transmit buffer can take another byte. Status bits 5..0 always read 1.
- R3: Writing 0xFF to offset 1 empties both buffers and leaves UART mode. It then leaves exactly one byte, 0xFE, in the receive buffer.
- R4: Writing 0x3F to offset 1 enters UART mode and queues the acknowledge byte 0xFE in the receive buffer.
- R5: A write of any other value to offset 1 changes neither the mode nor either buffer.
- R6: Reading offset 0 returns the oldest byte in the receive buffer and removes it, so bytes come out in arrival order. A read while the buffer is empty returns 0x00.
- R7: A write to offset 0 is queued for transmission only in UART mode. Outside UART mode it is dropped and the serial line stays idle.
- R8: Each transmitted frame has one low start bit, then 8 data bits LSB first, then one high stop bit, with each bit lasting CLK_DIV clock cycles. The line idles high.
- R9: In UART mode, a serial frame with a high stop bit places its byte in the receive buffer. Outside UART mode, incoming frames are dropped.
- R10: A byte that arrives while its buffer is full is dropped, and the bytes already held stay intact and in order.
- R11: After the reset input, the port is out of UART mode, both buffers are empty, and the status reads 0xBF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe; a read of offset 0 removes a byte |
| host_addr | input | 1 | 0 = data register, 1 = command/status register |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, decoded combinationally from host_addr |
| rx_avail | output | 1 | High while the receive buffer holds a byte |
| serial_in | input | 1 | Serial receive line, idle high |
| serial_out | output | 1 | Serial transmit line, idle high |

## Verification
A wrong mode bit shows up as soon as the next data write: the byte either appears on the serial line or fails to appear there within one frame time, and incoming frames are either kept or lost. Buffer occupancy is visible at once through status bits 7 and 6 on the next read. A corrupt pointer or count appears as data read back out of order, a missing acknowledge, or a stale byte after a reset command. Framing faults, such as the wrong bit length, the wrong bit order or a bad stop bit, show up within a single frame when the bench decodes the transmit line.

// File: rtl/midi_port_pkg.sv
package midi_port_pkg;
   localparam logic [7:0] CMD_RESET = 8'hFF;
   localparam logic [7:0] CMD_UART  = 8'h3F;
   localparam logic [7:0] ACK_BYTE  = 8'hFE;

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/mp_fifo.sv
module mp_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("mp_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp;
   logic [AW:0]      cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (clr) begin
         rp  <= '0;
         wp  <= push ? AW'(1) : '0;
         cnt <= push ? (AW+1)'(1) : '0;
         if (push) mem[0] <= din;
      end else begin
         if (push) begin
            mem[wp] <= din;
            wp      <= wp + AW'(1);
         end
         if (pop) rp <= rp + AW'(1);
         cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
      end
   end

   assign dout  = mem[rp];
   assign empty = (cnt == '0);
   assign full  = (cnt == (AW+1)'(DEPTH));

   // R10: the owner must drop bytes instead of pushing into a full buffer
   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !clr) |-> !full);
   // R6: removal only from a non-empty buffer
   p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !clr) |-> !empty);
endmodule

// File: rtl/mp_uart_tx.sv
module mp_uart_tx #(
   parameter int DIV = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] din,
   output logic       busy,
   output logic       txd
);
   localparam int CW = $clog2(DIV);

   logic [9:0]    sh;
   logic [CW-1:0] cnt;
   logic [3:0]    bitn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         cnt  <= '0;
         bitn <= '0;
         busy <= 1'b0;
      end else if (!busy) begin
         if (load) begin
            sh   <= {1'b1, din, 1'b0};
            cnt  <= '0;
            bitn <= '0;
            busy <= 1'b1;
         end
      end else if (cnt == CW'(DIV - 1)) begin
         cnt <= '0;
         if (bitn == 4'd9) begin
            busy <= 1'b0;
         end else begin
            sh   <= {1'b1, sh[9:1]};
            bitn <= bitn + 4'd1;
         end
      end else begin
         cnt <= cnt + CW'(1);
      end
   end

   assign txd = busy ? sh[0] : 1'b1;

   // R8: a frame opens with a low start bit
   p_start_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !txd);
   // R8: the last bit of a frame is high
   p_stop_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bitn == 4'd9) |-> txd);
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
   import midi_port_pkg::*;
#(
   parameter int DIV         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rxd,
   output logic       valid,
   output logic [7:0] dout
);
   localparam int CW   = $clog2(DIV);
   localparam int HALF = DIV / 2;

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("mp_uart_rx: SYNC_STAGES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q[g] <= 1'b1;
            else        sync_q[g] <= rxd;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q[g] <= 1'b1;
            else        sync_q[g] <= sync_q[g-1];
      end
   end

   logic          line;
   rx_state_t     state;
   logic [CW-1:0] cnt;
   logic [2:0]    bitn;
   logic [7:0]    sh;

   assign line = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= RX_IDLE;
         cnt   <= '0;
         bitn  <= '0;
         sh    <= '0;
         valid <= 1'b0;
      end else begin
         valid <= 1'b0;
         case (state)
            RX_IDLE: begin
               cnt <= '0;
               if (!line) state <= RX_START;
            end
            RX_START: begin
               if (cnt == CW'(HALF - 1)) begin
                  cnt   <= '0;
                  bitn  <= '0;
                  state <= line ? RX_IDLE : RX_DATA;
               end else cnt <= cnt + CW'(1);
            end
            RX_DATA: begin
               if (cnt == CW'(DIV - 1)) begin
                  cnt  <= '0;
                  sh   <= {line, sh[7:1]};
                  bitn <= bitn + 3'd1;
                  if (bitn == 3'd7) state <= RX_STOP;
               end else cnt <= cnt + CW'(1);
            end
            default: begin
               if (cnt == CW'(DIV - 1)) begin
                  cnt   <= '0;
                  state <= RX_IDLE;
                  valid <= line;
               end else cnt <= cnt + CW'(1);
            end
         endcase
      end
   end

   assign dout = sh;

   // R9: each completed frame yields a single-cycle strobe
   p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);
endmodule

// File: rtl/midi_uart_port.sv
module midi_uart_port
   import midi_port_pkg::*;
#(
   parameter int CLK_DIV     = 16,
   parameter int TX_DEPTH    = 4,
   parameter int RX_DEPTH    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_wr,
   input  logic       host_rd,
   input  logic       host_addr,
   input  logic [7:0] host_wdata,
   output logic [7:0] host_rdata,
   output logic       rx_avail,
   input  logic       serial_in,
   output logic       serial_out
);
   if (CLK_DIV < 4) begin : g_bad_div
      $error("midi_uart_port: CLK_DIV must be at least 4");
   end

   logic       uart_mode;
   logic       cmd_wr, is_reset, is_enter, ack_push;
   logic       tx_push, tx_pop, tx_empty, tx_full, tx_busy;
   logic [7:0] tx_dout;
   logic       rx_push, rx_pop, rx_empty, rx_full;
   logic [7:0] rx_din, rx_dout;
   logic       ser_valid;
   logic [7:0] ser_byte;
   logic       hold_v, src_v;
   logic [7:0] hold_b, src_b;

   assign cmd_wr   = host_wr && host_addr;
   assign is_reset = cmd_wr && (host_wdata == CMD_RESET);
   assign is_enter = cmd_wr && (host_wdata == CMD_UART);
   assign ack_push = is_reset || is_enter;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        uart_mode <= 1'b0;
      else if (is_reset) uart_mode <= 1'b0;
      else if (is_enter) uart_mode <= 1'b1;
   end

   // transmit side
   assign tx_push = host_wr && !host_addr && uart_mode && !tx_full;
   assign tx_pop  = !tx_busy && !tx_empty && !is_reset;

   mp_fifo #(.WIDTH(8), .DEPTH(TX_DEPTH)) tx_buf_i (
      .clk(clk), .rst_n(rst_n), .clr(is_reset), .push(tx_push), .pop(tx_pop),
      .din(host_wdata), .dout(tx_dout), .empty(tx_empty), .full(tx_full));

   mp_uart_tx #(.DIV(CLK_DIV)) ser_tx_i (
      .clk(clk), .rst_n(rst_n), .load(tx_pop), .din(tx_dout),
      .busy(tx_busy), .txd(serial_out));

   // receive side: acknowledge takes priority, a colliding serial byte waits one cycle
   mp_uart_rx #(.DIV(CLK_DIV), .SYNC_STAGES(SYNC_STAGES)) ser_rx_i (
      .clk(clk), .rst_n(rst_n), .rxd(serial_in), .valid(ser_valid), .dout(ser_byte));

   assign src_v = hold_v || (ser_valid && uart_mode);
   assign src_b = hold_v ? hold_b : ser_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_v <= 1'b0;
         hold_b <= '0;
      end else if (is_reset) begin
         hold_v <= 1'b0;
      end else if (ack_push && src_v) begin
         hold_v <= 1'b1;
         hold_b <= src_b;
      end else begin
         hold_v <= 1'b0;
      end
   end

   assign rx_push = ack_push ? (is_reset || !rx_full) : (src_v && !rx_full);
   assign rx_din  = ack_push ? ACK_BYTE : src_b;
   assign rx_pop  = host_rd && !host_addr && !rx_empty;

   mp_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) rx_buf_i (
      .clk(clk), .rst_n(rst_n), .clr(is_reset), .push(rx_push), .pop(rx_pop),
      .din(rx_din), .dout(rx_dout), .empty(rx_empty), .full(rx_full));

   // host read path: status flags are active-low, spare bits read as ones
   assign host_rdata = host_addr ? {rx_empty, tx_full, 6'h3F}
                                 : (rx_empty ? 8'h00 : rx_dout);
   assign rx_avail   = !rx_empty;

   // R3: reset command always leaves UART mode and a pending acknowledge
   p_reset_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      is_reset |=> (!uart_mode && !rx_empty));
   // R4: enter command switches mode
   p_enter_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      is_enter |=> uart_mode);
   // R5: ignored command codes leave the mode unchanged
   p_other_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !ack_push) |=> $stable(uart_mode));
   // R7: nothing enters the transmit buffer outside UART mode
   p_tx_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !host_addr && !uart_mode) |=> $stable(tx_empty) || tx_empty);
endmodule

// File: tb/midi_uart_port_tb_top.sv
module midi_uart_port_tb_top;
   localparam int DIV   = 16;
   localparam int DEPTH = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0, host_rd = 1'b0, host_addr = 1'b1;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       rx_avail;
   logic       serial_in = 1'b1;
   logic       serial_out;

   always #10 clk = ~clk;

   midi_uart_port #(.CLK_DIV(DIV), .TX_DEPTH(DEPTH), .RX_DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .rx_avail(rx_avail), .serial_in(serial_in), .serial_out(serial_out));

   int checks = 0, failures = 0;
   logic [7:0] tx_log [64];
   logic       tx_stop [64];
   int         tx_n = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_status(input int rx_cnt, input bit tx_full);
      return {rx_cnt == 0, tx_full, 6'h3F};
   endfunction

   // frame decoder on the transmit line
   always begin
      logic [7:0] b;
      @(negedge clk);
      if (rst_n && serial_out === 1'b0) begin
         repeat (DIV / 2) @(negedge clk);
         for (int i = 0; i < 8; i++) begin
            repeat (DIV) @(negedge clk);
            b[i] = serial_out;
         end
         repeat (DIV) @(negedge clk);
         tx_stop[tx_n] = serial_out;
         tx_log[tx_n]  = b;
         tx_n++;
      end
   end

   task automatic host_write(input logic a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; host_addr = 1'b1;
   endtask

   task automatic host_read(output logic [7:0] v);
      @(negedge clk);
      host_addr = 1'b0; host_rd = 1'b1;
      #1 v = host_rdata;
      @(negedge clk);
      host_rd = 1'b0; host_addr = 1'b1;
   endtask

   task automatic read_status(output logic [7:0] v);
      @(negedge clk);
      host_addr = 1'b1;
      #1 v = host_rdata;
   endtask

   task automatic send_serial(input logic [7:0] b);
      @(negedge clk);
      serial_in = 1'b0;
      repeat (DIV) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         serial_in = b[i];
         repeat (DIV) @(negedge clk);
      end
      serial_in = 1'b1;
      repeat (DIV) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic wait_tx(input int n);
      for (int i = 0; i < 4000 && tx_n < n; i++) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic [7:0] bytes [8];
      int base, low_len;
      void'($urandom(32'd1234));

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      read_status(v);
      chk(v == 8'hBF, "R11 status after reset", v, 8'hBF);
      chk(rx_avail == 1'b0, "R1 rx_avail after reset", rx_avail, 0);

      // data before UART mode is dropped
      host_write(1'b0, 8'h55);
      repeat (400) @(negedge clk);
      chk(tx_n == 0, "R7 write outside UART mode", tx_n, 0);

      // unknown commands
      host_write(1'b1, 8'h12);
      host_write(1'b1, 8'h00);
      read_status(v);
      chk(v == exp_status(0, 0), "R5 no ack for other command", v, exp_status(0, 0));
      host_write(1'b0, 8'h66);
      repeat (400) @(negedge clk);
      chk(tx_n == 0, "R5 mode unchanged", tx_n, 0);

      // enter UART mode
      host_write(1'b1, 8'h3F);
      read_status(v);
      chk(v == exp_status(1, 0), "R4 ack pending", v, exp_status(1, 0));
      chk(rx_avail == 1'b1, "R1 rx_avail with ack", rx_avail, 1);
      host_read(v);
      chk(v == 8'hFE, "R4 ack byte", v, 8'hFE);
      read_status(v);
      chk(v == exp_status(0, 0), "R6 buffer empty after pop", v, exp_status(0, 0));

      // directed frame: start bit length
      host_write(1'b0, 8'h01);
      for (int i = 0; i < 200 && serial_out !== 1'b0; i++) @(negedge clk);
      low_len = 0;
      while (serial_out === 1'b0 && low_len < 100) begin
         @(negedge clk);
         low_len++;
      end
      chk(low_len == DIV, "R8 start bit length", low_len, DIV);
      wait_tx(1);
      chk(tx_n == 1 && tx_log[0] == 8'h01 && tx_stop[0], "R8 frame 0x01", tx_log[0], 8'h01);

      // random single frames
      for (int k = 0; k < 6; k++) begin
         logic [7:0] r;
         r = 8'($urandom);
         base = tx_n;
         host_write(1'b0, r);
         wait_tx(base + 1);
         chk(tx_n == base + 1 && tx_log[base] == r && tx_stop[base],
             "R7 R8 random frame", tx_log[base], r);
      end

      // burst: one in the shifter, DEPTH queued, last dropped
      repeat (3 * DIV) @(negedge clk);
      base = tx_n;
      for (int k = 0; k < DEPTH + 2; k++) begin
         bytes[k] = 8'($urandom);
         host_write(1'b0, bytes[k]);
      end
      read_status(v);
      chk(v == exp_status(0, 1), "R2 transmit buffer full", v, exp_status(0, 1));
      wait_tx(base + DEPTH + 1);
      repeat (400) @(negedge clk);
      chk(tx_n == base + DEPTH + 1, "R10 extra tx byte dropped", tx_n - base, DEPTH + 1);
      for (int k = 0; k <= DEPTH; k++)
         chk(tx_log[base + k] == bytes[k], "R10 tx order kept", tx_log[base + k], bytes[k]);
      read_status(v);
      chk(v == exp_status(0, 0), "R2 space again", v, exp_status(0, 0));

      // receive path in order
      for (int k = 0; k < 3; k++) begin
         bytes[k] = 8'($urandom);
         send_serial(bytes[k]);
      end
      read_status(v);
      chk(v == exp_status(3, 0), "R1 bytes waiting", v, exp_status(3, 0));
      for (int k = 0; k < 3; k++) begin
         host_read(v);
         chk(v == bytes[k], "R9 R6 received byte in order", v, bytes[k]);
      end
      host_read(v);
      chk(v == 8'h00, "R6 empty read", v, 8'h00);
      chk(rx_avail == 1'b0, "R1 rx_avail cleared", rx_avail, 0);

      // receive overflow
      for (int k = 0; k < DEPTH + 1; k++) begin
         bytes[k] = 8'($urandom);
         send_serial(bytes[k]);
      end
      for (int k = 0; k < DEPTH; k++) begin
         host_read(v);
         chk(v == bytes[k], "R10 rx kept bytes", v, bytes[k]);
      end
      read_status(v);
      chk(v == exp_status(0, 0), "R10 extra rx byte dropped", v, exp_status(0, 0));

      // reset command with bytes pending
      send_serial(8'hA5);
      send_serial(8'h3C);
      host_write(1'b1, 8'hFF);
      read_status(v);
      chk(v == exp_status(1, 0), "R3 single ack after reset cmd", v, exp_status(1, 0));
      host_read(v);
      chk(v == 8'hFE, "R3 ack byte", v, 8'hFE);
      read_status(v);
      chk(v == exp_status(0, 0), "R3 receive buffer emptied", v, exp_status(0, 0));
      base = tx_n;
      host_write(1'b0, 8'h77);
      repeat (400) @(negedge clk);
      chk(tx_n == base, "R3 UART mode left", tx_n - base, 0);
      send_serial(8'h42);
      read_status(v);
      chk(v == exp_status(0, 0), "R9 frame ignored outside UART mode", v, exp_status(0, 0));

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule